// File: doc/BRIEF.md
# Four-Bit Multi-Function Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It takes two 4-bit operands and a 3-bit function code, and it returns an 8-bit result. Every candidate result is formed in parallel: a gate-level ripple-carry sum, a sum from the language's own addition operator, a split logic word, an any-bit-set flag and an operand join. A decoded one-hot strobe word then picks one of these candidates.

The ripple-carry adder is a chain of full-adder cells, each written as gate equations. Its carry-out is kept in the result. The increment and the structural add share this one adder: during an increment its second operand is forced to one. Function codes with no assigned meaning give an all-zero word. The result follows the inputs within the same cycle, with no storage anywhere in the block.

Top module: `mini_alu`

## Requirements
- R1: Function code 0 gives opA + 1 from the ripple adder, as a 5-bit unsigned value in result[4:0], with result[7:5] = 0 (for example, opA = 4'hF gives 8'h10).
- R2: Function code 1 gives opA + opB from the ripple adder, with the sum in result[3:0], the carry-out in result[4] and result[7:5] = 0.
- R3: Function code 2 gives opA + opB from the built-in addition operator, in the same layout as code 1. It is equal to the code-1 result for every operand pair.
- R4: Function code 3 places opA XOR opB in result[3:0] and opA OR opB in result[7:4].
- R5: Function code 4 gives 8'h01 when any of the eight operand bits is 1, and 8'h00 when all eight bits are 0.
- R6: Function code 5 gives the join of the operands, with opA in result[7:4] and opB in result[3:0].
- R7: Function codes 6 and 7 give 8'h00 for every operand pair.
- R8: The carry passes through all four adder stages: 4'hF + 4'h1 gives 8'h10, 4'hF + 4'hF gives 8'h1E, and 4'h8 + 4'h8 gives 8'h10.
- R9: The result depends only on the present inputs. After any change of the inputs, it shows the new value without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| funcSel | input | 3 | Function code |
| result | output | 8 | Selected result |

## Verification
The structural ripple sum and the built-in-operator sum are computed at the same time from the same operands. Any disagreement between them would go unnoticed if only one of them were ever selected. The bench sweeps all 256 operand pairs under code 1 and again under code 2, then checks that each matches one independent expected sum. An assertion inside the datapath compares the two sums directly whenever the ripple path is the one selected. Random operand and code mixes then move the inputs between codes in consecutive cycles, which shows that no earlier selection leaves a trace in the result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_INCR   = 3'd0,
    FN_RIPPLE = 3'd1,
    FN_NATIVE = 3'd2,
    FN_SPLIT  = 3'd3,
    FN_ANYONE = 3'd4,
    FN_JOIN   = 3'd5
  } aluFunc_e;

  typedef struct packed {
    logic selIncr;
    logic selRipple;
    logic selNative;
    logic selSplit;
    logic selAnyOne;
    logic selJoin;
  } aluStrobe_t;
endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic halfX;
  assign halfX = a ^ b;
  assign s     = halfX ^ ci;
  assign co    = (a & b) | (ci & halfX);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] addA,
  input  logic [OPW-1:0] addB,
  input  logic           carryIn,
  output logic [OPW-1:0] sumOut,
  output logic           carryOut
);
  logic [OPW:0] carryChain;
  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < OPW; i++) begin : g_stage
    alu_fa_cell u_cell (
      .a  (addA[i]),
      .b  (addB[i]),
      .ci (carryChain[i]),
      .s  (sumOut[i]),
      .co (carryChain[i+1])
    );
  end

  assign carryOut = carryChain[OPW];

  // R8: the chained cells must agree with a plain reference sum
  always_comb begin
    // R8
    ripple_sum_chk: assert ({carryOut, sumOut} ==
                            ({1'b0, addA} + {1'b0, addB} + {{OPW{1'b0}}, carryIn}))
      else $error("ripple adder disagrees with reference sum");
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [FUNC_W-1:0] funcSel,
  output aluStrobe_t        strb
);
  always_comb begin
    strb = '0;
    case (funcSel)
      FN_INCR:   strb.selIncr   = 1'b1;
      FN_RIPPLE: strb.selRipple = 1'b1;
      FN_NATIVE: strb.selNative = 1'b1;
      FN_SPLIT:  strb.selSplit  = 1'b1;
      FN_ANYONE: strb.selAnyOne = 1'b1;
      FN_JOIN:   strb.selJoin   = 1'b1;
      default:   strb = '0;
    endcase
  end

  always_comb begin
    // R7
    onehot_strb_chk: assert ($onehot0(strb))
      else $error("more than one function strobe active");
    // R7
    unused_code_chk: assert (!(funcSel >= 3'd6) || (strb == '0))
      else $error("unassigned code raised a strobe");
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int OPW = 4,
  localparam int RESW = 2 * OPW
) (
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  aluStrobe_t      strb,
  output logic [RESW-1:0] result
);
  localparam logic [OPW-1:0] ONE = {{(OPW-1){1'b0}}, 1'b1};

  logic [OPW-1:0]  addB;
  logic [OPW-1:0]  rippleSum;
  logic            rippleCarry;
  logic [OPW:0]    rippleFull;
  logic [OPW:0]    nativeFull;
  logic [RESW-1:0] arithWord;
  logic [RESW-1:0] nativeWord;
  logic [RESW-1:0] splitWord;
  logic [RESW-1:0] anyWord;
  logic [RESW-1:0] joinWord;

  // one shared adder: increment forces the second operand to one
  assign addB = strb.selIncr ? ONE : opB;

  alu_ripple_adder #(.OPW(OPW)) u_ripple (
    .addA     (opA),
    .addB     (addB),
    .carryIn  (1'b0),
    .sumOut   (rippleSum),
    .carryOut (rippleCarry)
  );

  assign rippleFull = {rippleCarry, rippleSum};
  assign nativeFull = {1'b0, opA} + {1'b0, opB};

  assign arithWord  = {{(RESW-OPW-1){1'b0}}, rippleFull};
  assign nativeWord = {{(RESW-OPW-1){1'b0}}, nativeFull};
  assign splitWord  = {opA | opB, opA ^ opB};
  assign anyWord    = {{(RESW-1){1'b0}}, |{opA, opB}};
  assign joinWord   = {opA, opB};

  always_comb begin
    result = '0;
    if (strb.selIncr || strb.selRipple) result = arithWord;
    if (strb.selNative)                 result = nativeWord;
    if (strb.selSplit)                  result = splitWord;
    if (strb.selAnyOne)                 result = anyWord;
    if (strb.selJoin)                   result = joinWord;
  end

  always_comb begin
    // R3
    sum_paths_chk: assert (!strb.selRipple || (rippleFull == nativeFull))
      else $error("ripple and native sums differ");
    // R1
    arith_top_zero_chk: assert (!(strb.selIncr || strb.selRipple || strb.selNative)
                                || (result[RESW-1:OPW+1] == '0))
      else $error("arithmetic result upper bits not zero");
    // R7
    idle_zero_chk: assert ((strb != '0) || (result == '0))
      else $error("no strobe but result nonzero");
    // R6
    join_high_chk: assert (!strb.selJoin || (result[RESW-1:OPW] == opA))
      else $error("join high nibble is not opA");
  end
endmodule

// File: rtl/mini_alu.sv
module mini_alu
  import alu_pkg::*;
#(
  parameter int OPW = 4,
  localparam int RESW = 2 * OPW
) (
  input  logic [OPW-1:0]    opA,
  input  logic [OPW-1:0]    opB,
  input  logic [FUNC_W-1:0] funcSel,
  output logic [RESW-1:0]   result
);
  aluStrobe_t strb;

  alu_ctrl u_ctrl (
    .funcSel (funcSel),
    .strb    (strb)
  );

  alu_dpath #(.OPW(OPW)) u_dpath (
    .opA    (opA),
    .opB    (opB),
    .strb   (strb),
    .result (result)
  );
endmodule

// File: tb/mini_alu_bench.sv
`timescale 1ns/1ps
module mini_alu_bench;
  logic       clk = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [2:0] funcSel = 3'd6;
  logic [7:0] result;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mini_alu u_mini_alu (.opA(opA), .opB(opB), .funcSel(funcSel), .result(result));

  function automatic logic [7:0] expectOf(input logic [2:0] f, input logic [3:0] a, input logic [3:0] b);
    int s;
    case (f)
      3'd0: begin s = int'(a) + 1;       return 8'(s); end
      3'd1, 3'd2: begin s = int'(a) + int'(b); return 8'(s); end
      3'd3: return {a | b, a ^ b};
      3'd4: return ((a != 0) || (b != 0)) ? 8'h01 : 8'h00;
      3'd5: return {a, b};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    compared++;
    if (result !== exp) begin
      mismatched++;
      $display("FAIL %s: sel=%0d A=%h B=%h got %h expected %h", tag, funcSel, opA, opB, result, exp);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic [3:0] a, input logic [3:0] b, input string tag);
    @(negedge clk);
    funcSel = f; opA = a; opB = b;
    #1;
    check(tag, expectOf(f, a, b));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    check("R7", 8'h00); // idle code at start
    // R8 carry corners
    apply(3'd1, 4'hF, 4'h1, "R8");
    apply(3'd1, 4'hF, 4'hF, "R8");
    apply(3'd1, 4'h8, 4'h8, "R8");
    apply(3'd0, 4'hF, 4'h0, "R8");
    apply(3'd2, 4'hF, 4'hF, "R8");
    apply(3'd4, 4'h0, 4'h0, "R5");
    apply(3'd4, 4'h0, 4'h8, "R5");
    // exhaustive sweep, all codes
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 256; p++)
        apply(3'(f), 4'(p >> 4), 4'(p), tagOf(3'(f)));
    // R3: both sum paths against one expected value
    for (int p = 0; p < 256; p++) begin
      apply(3'd1, 4'(p >> 4), 4'(p), "R3");
      apply(3'd2, 4'(p >> 4), 4'(p), "R3");
    end
    // R9: random mix, inputs change with no clock dependency
    for (int i = 0; i < 1000; i++) begin
      logic [2:0] f;
      logic [3:0] a;
      logic [3:0] b;
      f = 3'($urandom); a = 4'($urandom); b = 4'($urandom);
      @(negedge clk);
      funcSel = f; opA = a; opB = b;
      #0.5;
      check("R9", expectOf(f, a, b));
      b = ~b;
      opB = b;
      #0.5;
      check("R9", expectOf(f, a, b));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule